// File: doc/BRIEF.md
# Rotating-Priority Bus Arbiter

This block decides which of four bus masters may drive a shared bus: a host CPU and three external masters. Request line 2 serves a south-bridge master that needs a raised priority. All requests and grants are active low, and at most one grant is low in any cycle. Grants come from a register, so a grant changes one clock edge after the request pattern that caused it.

The priority order comes from a 3-bit code. The code drives a binary decision tree that has three levels:
- the root sets the CPU against the external masters as a group;
- the next level orders request 0 against request 1;
- the last level places request 2 ahead of or behind that pair.

A request permuter sorts the active requests into slot order. A first-set selector picks the winner, and a grant permuter maps the winning slot back onto its physical grant line.

Each code bit comes either from a fixed configuration code or from a rotation state. The rotation state is updated on every grant issued to a requesting master. Two programmable counts bound how long the CPU, and how long request 2, stay demoted after they win. Further options control bus parking, preemption of a held grant, and an idle clock between grants.

Top module: `rprio_arbiter`

## Requirements
- R1: While `rst_ni` is low, and on release before the first clock edge, all four grants are high. The rotation state restarts with the CPU on top, request 0 ahead of request 1, request 2 ahead of the pair, and both counts at zero.
- R2: At most one grant is low in any cycle. When any request is pending, a newly asserted grant goes only to a master that requested in the cycle before. Grants are registered and respond one clock edge after the request pattern.
- R3: The code c[2:0] sets the order. c[2]=0 puts the CPU first and c[2]=1 puts it last. c[1]=0 ranks request 0 above request 1, and c[1]=1 reverses them. c[0]=0 ranks request 2 above both, and c[0]=1 ranks it below both. The highest-ranked pending request wins.
- R4: `mode_i` picks the source of each code bit. 0: all three bits from `fix_code_i`. 1: all from the rotation state. 2: c[2] from the rotation state, c[1:0] fixed. 3: c[2] fixed, c[1:0] from the rotation state. The rotation state is {cpu_low, pair, sb_low}.
- R5: A grant issued to the CPU sets cpu_low. After that, cpu_low clears on the (`cpu_lim_i`+1)-th external grant, so 1 to 8 external grants pass before the CPU is back on top.
- R6: A grant issued to request 2 sets sb_low. After that, sb_low clears on the (`sb_lim_i`+1)-th grant to request 0 or request 1.
- R7: A grant issued to request 0 sets pair to 1, and a grant issued to request 1 clears it.
- R8: With preemption off, a granted master keeps its grant for as long as it requests.
- R9: With no request pending, the grant parks on the last master granted through arbitration when `park_en_i` is high. Otherwise it parks on the CPU. The last master is the CPU after reset.
- R10: With preemption on, a held grant is re-arbitrated in any cycle where another master requests, even if the holder still requests.
- R11: With `idle_en_i` high, moving the grant from one master to a different one passes through one cycle in which all grants are high.
- R12: The rotation state changes only on an issue to a requesting winner, including a re-issue to the holder under preemption. A parked grant that its master starts using does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_ni | input | 1 | CPU request, active low |
| req_ni | input | 3 | External master requests, active low; bit 2 is the south-bridge line |
| mode_i | input | 2 | Priority source select (R4) |
| fix_code_i | input | 3 | Fixed priority code |
| cpu_lim_i | input | CNT_W | External grants before the CPU returns to top, minus one |
| sb_lim_i | input | CNT_W | Grants to request 0/1 before request 2 returns ahead, minus one |
| park_en_i | input | 1 | Park on the last granted master |
| preempt_en_i | input | 1 | Allow a held grant to be taken away |
| idle_en_i | input | 1 | Insert one idle cycle between grants |
| cpu_gnt_no | output | 1 | CPU grant, active low |
| gnt_no | output | 3 | External grants, active low |

## Verification
The hardest state to reach is a counter that sits at its limit while both the CPU and request 2 are demoted, followed by the exact grant that restores them. Ordinary traffic rarely lines up the needed run of external grants. The stimulus keeps every request low with preemption on, so a new winner is issued on every clock. A fixed grant sequence then walks through demotion, counting and restoration in a few cycles. After that, phases sweep every limit value and every fixed code. Masters in these phases raise requests at random and drop them at random once granted, and a behavioural model built from ordered lists predicts every grant.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int N_MST   = 4;
  localparam int IDX_CPU = 3;

  typedef enum logic [1:0] {
    MODE_FIXED   = 2'd0,
    MODE_ROTATE  = 2'd1,
    MODE_HYB_CPU = 2'd2,
    MODE_HYB_EXT = 2'd3
  } arb_mode_e;

  // slot (0 = highest) of master m under code c
  function automatic logic [1:0] slot_of(logic [2:0] c, int m);
    logic [1:0] pair_pos, ext_pos, base;
    if (m == IDX_CPU) return c[2] ? 2'd3 : 2'd0;
    pair_pos = (m == 0) ? {1'b0, c[1]} : {1'b0, ~c[1]};
    if (m == 2) ext_pos = c[0] ? 2'd2 : 2'd0;
    else        ext_pos = c[0] ? pair_pos : pair_pos + 2'd1;
    base = c[2] ? 2'd0 : 2'd1;
    return base + ext_pos;
  endfunction
endpackage

// File: rtl/arb_permuter.sv
module arb_permuter
  import arb_pkg::*;
#(
  parameter bit UNSORT = 1'b0
) (
  input  logic [2:0]       code_i,
  input  logic [N_MST-1:0] d_i,
  output logic [N_MST-1:0] q_o
);
  generate
    if (UNSORT) begin : g_unsort
      always_comb begin
        for (int m = 0; m < N_MST; m++) q_o[m] = d_i[slot_of(code_i, m)];
      end
    end else begin : g_sort
      always_comb begin
        q_o = '0;
        for (int m = 0; m < N_MST; m++) q_o[slot_of(code_i, m)] = d_i[m];
      end
    end
  endgenerate
endmodule

// File: rtl/arb_selector.sv
module arb_selector #(
  parameter int N = 4
) (
  input  logic [N-1:0] d_i,
  output logic [N-1:0] oh_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    oh_o  = '0;
    for (int i = 0; i < N; i++) begin
      if (d_i[i] && !found) begin
        oh_o[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/arb_rot_fsm.sv
module arb_rot_fsm
  import arb_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic [N_MST-1:0] win_i,
  input  logic [CNT_W-1:0] cpu_lim_i,
  input  logic [CNT_W-1:0] sb_lim_i,
  output logic [2:0]       rot_o
);
  logic             cpu_low_q, sb_low_q, pair_q;
  logic [CNT_W-1:0] cpu_cnt_q, sb_cnt_q;
  logic             ext_win, pair_win;

  assign ext_win  = |win_i[IDX_CPU-1:0];
  assign pair_win = win_i[0] | win_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_low_q <= 1'b0;
      cpu_cnt_q <= '0;
      sb_low_q  <= 1'b0;
      sb_cnt_q  <= '0;
      pair_q    <= 1'b0;
    end else if (issue_i) begin
      if (win_i[IDX_CPU]) begin
        cpu_low_q <= 1'b1;
        cpu_cnt_q <= '0;
      end else if (ext_win && cpu_low_q) begin
        if (cpu_cnt_q == cpu_lim_i) begin
          cpu_low_q <= 1'b0;
          cpu_cnt_q <= '0;
        end else begin
          cpu_cnt_q <= cpu_cnt_q + 1'b1;
        end
      end
      if (win_i[2]) begin
        sb_low_q <= 1'b1;
        sb_cnt_q <= '0;
      end else if (pair_win && sb_low_q) begin
        if (sb_cnt_q == sb_lim_i) begin
          sb_low_q <= 1'b0;
          sb_cnt_q <= '0;
        end else begin
          sb_cnt_q <= sb_cnt_q + 1'b1;
        end
      end
      if (win_i[0])      pair_q <= 1'b1;
      else if (win_i[1]) pair_q <= 1'b0;
    end
  end

  assign rot_o = {cpu_low_q, pair_q, sb_low_q};

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(cpu_lim_i) && cpu_cnt_q <= cpu_lim_i) |=> (cpu_cnt_q <= $past(cpu_lim_i)));
  p_sb_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(sb_lim_i) && sb_cnt_q <= sb_lim_i) |=> (sb_cnt_q <= $past(sb_lim_i)));
endmodule

// File: rtl/rprio_arbiter.sv
module rprio_arbiter
  import arb_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpu_req_ni,
  input  logic [2:0]       req_ni,
  input  logic [1:0]       mode_i,
  input  logic [2:0]       fix_code_i,
  input  logic [CNT_W-1:0] cpu_lim_i,
  input  logic [CNT_W-1:0] sb_lim_i,
  input  logic             park_en_i,
  input  logic             preempt_en_i,
  input  logic             idle_en_i,
  output logic             cpu_gnt_no,
  output logic [2:0]       gnt_no
);
  localparam logic [N_MST-1:0] CPU_OH = N_MST'(1) << IDX_CPU;

  logic [N_MST-1:0] req_act, sorted, sel, win;
  logic [N_MST-1:0] gnt_q, gnt_d, last_q, park_tgt;
  logic [2:0]       rot, fix_mask, code;
  logic             any_req, holder_req, others, keep, issue;

  assign req_act = {~cpu_req_ni, ~req_ni};

  always_comb begin
    unique case (arb_mode_e'(mode_i))
      MODE_FIXED:   fix_mask = 3'b111;
      MODE_ROTATE:  fix_mask = 3'b000;
      MODE_HYB_CPU: fix_mask = 3'b011;
      default:      fix_mask = 3'b100;
    endcase
  end
  assign code = (fix_mask & fix_code_i) | (~fix_mask & rot);

  arb_permuter #(.UNSORT(1'b0)) u_req_perm (.code_i(code), .d_i(req_act), .q_o(sorted));
  arb_selector #(.N(N_MST))     u_sel      (.d_i(sorted), .oh_o(sel));
  arb_permuter #(.UNSORT(1'b1)) u_gnt_perm (.code_i(code), .d_i(sel), .q_o(win));

  arb_rot_fsm #(.CNT_W(CNT_W)) u_rot (
    .clk_i, .rst_ni, .issue_i(issue), .win_i(win),
    .cpu_lim_i, .sb_lim_i, .rot_o(rot)
  );

  assign any_req    = |req_act;
  assign holder_req = |(gnt_q & req_act);
  assign others     = |(req_act & ~gnt_q);
  assign keep       = holder_req && !(preempt_en_i && others);
  assign park_tgt   = park_en_i ? last_q : CPU_OH;

  always_comb begin
    gnt_d = gnt_q;
    issue = 1'b0;
    if (!keep) begin
      if (!any_req) begin
        gnt_d = (idle_en_i && gnt_q != '0 && gnt_q != park_tgt) ? '0 : park_tgt;
      end else if (idle_en_i && gnt_q != '0 && win != gnt_q) begin
        gnt_d = '0;
      end else begin
        gnt_d = win;
        issue = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q  <= '0;
      last_q <= CPU_OH;
    end else begin
      gnt_q <= gnt_d;
      if (issue) last_q <= win;
    end
  end

  assign cpu_gnt_no = ~gnt_q[IDX_CPU];
  assign gnt_no     = ~gnt_q[IDX_CPU-1:0];

  p_one_grant_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~{cpu_gnt_no, gnt_no}));
  p_grant_to_requester_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_req |=> ((~{cpu_gnt_no, gnt_no}) == '0 || |((~{cpu_gnt_no, gnt_no}) & $past(req_act))));
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!preempt_en_i && |((~{cpu_gnt_no, gnt_no}) & req_act))
      |=> ({cpu_gnt_no, gnt_no} == $past({cpu_gnt_no, gnt_no})));
  p_park_cpu_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_req && !park_en_i && !idle_en_i) |=> (!cpu_gnt_no && gnt_no == 3'b111));
  p_idle_gap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_en_i && {cpu_gnt_no, gnt_no} != 4'b1111)
      |=> ({cpu_gnt_no, gnt_no} == $past({cpu_gnt_no, gnt_no}) || {cpu_gnt_no, gnt_no} == 4'b1111));
endmodule

// File: tb/sim_rprio_arbiter.sv
`timescale 1ns/1ps
module sim_rprio_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_req_n = 1'b1;
  logic [2:0] req_n = 3'b111;
  logic [1:0] mode = 2'd1;
  logic [2:0] fix_code = 3'd0;
  logic [2:0] cpu_lim = 3'd0, sb_lim = 3'd0;
  logic       park_en = 1'b0, preempt_en = 1'b0, idle_en = 1'b0;
  logic       cpu_gnt_n;
  logic [2:0] gnt_n;

  int vectors = 0, fails = 0;
  string tag = "R1";

  // reference state: grant index -1 none, 0..2 external, 3 CPU
  int m_gnt, m_last, cpu_low, cpu_cnt, pair, sb_low, sb_cnt;
  bit rq [4];

  always #10 clk = ~clk;

  rprio_arbiter #(.CNT_W(3)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cpu_req_ni(cpu_req_n), .req_ni(req_n),
    .mode_i(mode), .fix_code_i(fix_code), .cpu_lim_i(cpu_lim), .sb_lim_i(sb_lim),
    .park_en_i(park_en), .preempt_en_i(preempt_en), .idle_en_i(idle_en),
    .cpu_gnt_no(cpu_gnt_n), .gnt_no(gnt_n)
  );

  function automatic logic [3:0] exp_vec(int g);
    logic [3:0] v = 4'b1111;
    if (g >= 0) v[g] = 1'b0;
    return v;
  endfunction

  function automatic int pick(int c2, int c1, int c0);
    int pr[$], ex[$], full[$];
    pr = c1 ? '{1, 0} : '{0, 1};
    ex = c0 ? '{pr[0], pr[1], 2} : '{2, pr[0], pr[1]};
    full = c2 ? '{ex[0], ex[1], ex[2], 3} : '{3, ex[0], ex[1], ex[2]};
    foreach (full[i]) if (rq[full[i]]) return full[i];
    return -1;
  endfunction

  task automatic model_reset();
    m_gnt = -1; m_last = 3; cpu_low = 0; cpu_cnt = 0; pair = 0; sb_low = 0; sb_cnt = 0;
  endtask

  task automatic model_step();
    int c2, c1, c0, w, tgt;
    bit any, others, keep;
    rq[0] = !req_n[0]; rq[1] = !req_n[1]; rq[2] = !req_n[2]; rq[3] = !cpu_req_n;
    any = rq[0] | rq[1] | rq[2] | rq[3];
    others = 0;
    for (int i = 0; i < 4; i++) if (rq[i] && i != m_gnt) others = 1;
    keep = (m_gnt >= 0) && rq[m_gnt] && !(preempt_en && others);
    c2 = (mode == 0 || mode == 3) ? fix_code[2] : cpu_low;
    c1 = (mode == 0 || mode == 2) ? fix_code[1] : pair;
    c0 = (mode == 0 || mode == 2) ? fix_code[0] : sb_low;
    if (keep) return;
    if (!any) begin
      tgt = park_en ? m_last : 3;
      m_gnt = (idle_en && m_gnt >= 0 && m_gnt != tgt) ? -1 : tgt;
      return;
    end
    w = pick(c2, c1, c0);
    if (idle_en && m_gnt >= 0 && w != m_gnt) begin
      m_gnt = -1;
      return;
    end
    m_gnt = w; m_last = w;
    if (w == 3) begin cpu_low = 1; cpu_cnt = 0; end
    else if (cpu_low == 1) begin
      if (cpu_cnt == int'(cpu_lim)) begin cpu_low = 0; cpu_cnt = 0; end
      else cpu_cnt++;
    end
    if (w == 2) begin sb_low = 1; sb_cnt = 0; end
    else if (w < 2 && sb_low == 1) begin
      if (sb_cnt == int'(sb_lim)) begin sb_low = 0; sb_cnt = 0; end
      else sb_cnt++;
    end
    if (w == 0) pair = 1;
    else if (w == 1) pair = 0;
  endtask

  task automatic check(logic [3:0] exp, string what);
    logic [3:0] act = {cpu_gnt_n, gnt_n};
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // one clock: inputs set at negedge, model on edge, compare at next negedge
  task automatic step_cmp();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(exp_vec(m_gnt), "model");
  endtask

  task automatic traffic(int n, int rise_div, int drop_div);
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < 4; i++) begin
        bit cur = (i == 3) ? !cpu_req_n : !req_n[i];
        if (cur && m_gnt == i && ($urandom % drop_div) == 0) cur = 0;
        else if (!cur && ($urandom % rise_div) == 0) cur = 1;
        if (i == 3) cpu_req_n = !cur; else req_n[i] = !cur;
      end
      step_cmp();
    end
  endtask

  initial begin
    int seq[7] = '{3, 2, 0, 3, 2, 1, 3};
    model_reset();
    repeat (3) @(negedge clk);
    tag = "R1"; check(4'b1111, "grants in reset");
    cpu_req_n = 1'b0; req_n = 3'b000;
    mode = 2'd1; cpu_lim = 3'd1; sb_lim = 3'd0; preempt_en = 1'b1;
    rst_n = 1'b1;
    check(4'b1111, "after release before edge");
    // constant requests under preemption: CPU demote/restore, REQ2 demote, pair swap
    for (int k = 0; k < 7; k++) begin
      @(posedge clk); model_step(); @(negedge clk);
      tag = (k == 3 || k == 6) ? "R5" : (k == 2 || k == 5) ? "R7" : (k == 4) ? "R6" : "R10";
      check(exp_vec(seq[k]), "directed sequence");
      check(exp_vec(m_gnt), "model on directed sequence");
    end
    preempt_en = 1'b0;
    cpu_req_n = 1'b1; req_n = 3'b111;
    tag = "R9"; step_cmp(); step_cmp();
    tag = "R3"; mode = 2'd0;
    for (int c = 0; c < 8; c++) begin fix_code = 3'(c); traffic(150, 3, 3); end
    tag = "R4";
    for (int m = 2; m < 4; m++)
      for (int c = 0; c < 8; c++) begin mode = 2'(m); fix_code = 3'(c); traffic(80, 3, 2); end
    tag = "R5"; mode = 2'd1;
    for (int l = 0; l < 8; l++) begin cpu_lim = 3'(l); sb_lim = 3'($urandom % 8); traffic(200, 2, 2); end
    tag = "R6";
    for (int l = 0; l < 8; l++) begin sb_lim = 3'(l); traffic(200, 2, 2); end
    tag = "R7"; mode = 2'd3; fix_code = 3'b000; traffic(300, 2, 2);
    tag = "R8"; mode = 2'd1; traffic(400, 2, 6);
    tag = "R9"; park_en = 1'b1; traffic(400, 8, 2);
    park_en = 1'b0; traffic(300, 8, 2);
    tag = "R10"; preempt_en = 1'b1; traffic(500, 3, 4);
    tag = "R11"; preempt_en = 1'b0; idle_en = 1'b1; traffic(500, 3, 3);
    tag = "R12"; park_en = 1'b1; preempt_en = 1'b1;
    for (int m = 0; m < 4; m++) begin mode = 2'(m); fix_code = 3'($urandom % 8); traffic(400, 5, 3); end
    idle_en = 1'b0; traffic(400, 5, 3);
    tag = "R2"; park_en = 1'b0; preempt_en = 1'b0; mode = 2'd1; traffic(600, 2, 3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL %s watchdog: actual hung expected done", tag);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule